// File: doc/BRIEF.md
# Parallel Printer Port Register Block

The block is a byte-wide printer port seen by a small host bus through an eight-location register window. A host access is one cycle with `acc_en` high: `acc_we` picks write or read, and `acc_addr` picks the location. Three locations are live: an output data byte, a status byte and a control byte. Reads are combinational from the current state, so the host samples `acc_rdata` in the same cycle. Side effects of the access take place at the closing clock edge.

Writing the control byte drives a printer handshake. The block holds the output byte on `lp_dout`. A strobe edge under select sends the byte, which shows as a one-cycle pulse on `lp_sent`. The status byte models the BUSY/ACK sequence a polling driver expects. Reading status advances that sequence and clears a pending interrupt. `lp_irq` is the pending flag gated by the control enable bit. The handshake lives in a three-state machine:

- `HS_RDY_NOACK`: BUSY and ACK both clear. This is the reset state.
- `HS_RDY_ACK`: ACK set, BUSY clear.
- `HS_BSY_ACK`: BUSY and ACK both set.

Four transitions move between them:

- **Init**: a control write with INIT clear goes from any state to `HS_BSY_ACK`.
- **Strobe**: a strobe write goes from `HS_BSY_ACK` to `HS_RDY_ACK`.
- **Ack drop**: a qualifying status poll goes from `HS_RDY_ACK` to `HS_RDY_NOACK`.
- **Reload**: a qualifying status poll goes from `HS_RDY_NOACK` to `HS_BSY_ACK`.

Top module: `lpt_port`

## Requirements
- R1: After reset the output data latch, the control byte and the status byte all read 0x00, the pending flag is clear and `lp_irq` is low.
- R2: Offsets are data 0, status 1 and control 2. Reads of offsets 3 to 7 return 0x00, and writes to them change nothing.
- R3: A write to offset 0 loads the output latch, which appears on `lp_dout` from the next cycle. A read of offset 0 returns `lp_din` when control bit 5 (direction) is set, and the output latch otherwise.
- R4: A control write with bit 2 (INIT) clear sets status bits 7 (BUSY), 6 (ACK), 4 (ONLINE) and 3 (ERROR), so status reads 0xD8.
- R5: A control write with bit 2 set, bit 3 (SELECT) set and bit 0 (STROBE) set clears status BUSY.
- R6: In the case of R5, if the stored control had STROBE clear, `lp_sent` is high for exactly the one cycle after the write, with the byte on `lp_dout`. If STROBE was already set, no pulse is made.
- R7: A control write with INIT and SELECT set and STROBE clear sets the pending flag only when the stored control had bit 4 (interrupt enable) set.
- R8: A control read returns the last written byte in full. The side effects of R5 to R7 are judged against the value held before the write.
- R9: A status read returns the status held before the read and clears the pending flag.
- R10: A status read when BUSY is clear and control STROBE is clear steps the status afterwards: a set ACK is cleared, and a clear ACK sets both ACK and BUSY. Otherwise the read leaves BUSY and ACK unchanged.
- R11: From the cycle after any access, `lp_irq` equals the pending flag AND control interrupt enable.
- R12: A write to the status offset changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_en | input | 1 | Host access this cycle |
| acc_we | input | 1 | 1 write, 0 read |
| acc_addr | input | 3 | Register offset in the window |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data for the addressed offset |
| lp_din | input | 8 | Input data byte from the cable side |
| lp_dout | output | 8 | Latched output data byte |
| lp_sent | output | 1 | One-cycle pulse when a byte is sent |
| lp_irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default eight-bit data width and three-bit window. That sizing puts every control and status bit position, and every one of the eight offsets, within reach of directed accesses. A behavioural model of the handshake runs beside the block and is compared on every clock. The sequences cover each of the four transitions, polls made while STROBE is held high, and a repeated strobe that must not send again. They also check interrupt enable toggled around a pending flag.

// File: rtl/lpt_pkg.sv
package lpt_pkg;
    localparam int CB_STROBE = 0;
    localparam int CB_INIT   = 2;
    localparam int CB_SELECT = 3;
    localparam int CB_INTEN  = 4;
    localparam int CB_DIR    = 5;

    localparam int SB_ERROR  = 3;
    localparam int SB_ONLINE = 4;
    localparam int SB_ACK    = 6;
    localparam int SB_BUSY   = 7;

    localparam int OFS_DATA = 0;
    localparam int OFS_STAT = 1;
    localparam int OFS_CTRL = 2;

    typedef enum logic [1:0] {
        HS_RDY_NOACK = 2'd0,
        HS_RDY_ACK   = 2'd1,
        HS_BSY_ACK   = 2'd2
    } hs_state_t;

    typedef struct packed {
        logic wr_data;
        logic wr_ctrl;
        logic rd_stat;
    } bus_evt_t;
endpackage

// File: rtl/lpt_bus_decode.sv
module lpt_bus_decode
    import lpt_pkg::*;
#(
    parameter int WIN_BITS = 3
) (
    input  logic                acc_en,
    input  logic                acc_we,
    input  logic [WIN_BITS-1:0] acc_addr,
    output bus_evt_t            evt
);
    localparam logic [WIN_BITS-1:0] A_DATA = WIN_BITS'(OFS_DATA);
    localparam logic [WIN_BITS-1:0] A_STAT = WIN_BITS'(OFS_STAT);
    localparam logic [WIN_BITS-1:0] A_CTRL = WIN_BITS'(OFS_CTRL);

    // R2, R12: only data and control writes and status reads have effects
    always_comb begin
        evt.wr_data = acc_en &&  acc_we && (acc_addr == A_DATA);
        evt.wr_ctrl = acc_en &&  acc_we && (acc_addr == A_CTRL);
        evt.rd_stat = acc_en && !acc_we && (acc_addr == A_STAT);
    end
endmodule

// File: rtl/lpt_ctrl_unit.sv
module lpt_ctrl_unit
    import lpt_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bus_evt_t          evt,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] ctrl_q,
    output logic [DATA_W-1:0] ctrl_d,
    output logic [DATA_W-1:0] dout_q,
    output logic              init_evt,
    output logic              strobe_evt,
    output logic              set_pend,
    output logic              sent_q
);
    logic armed;
    logic emit_evt;
    logic [DATA_W-1:0] dout_d;

    // R5-R8: decisions use the stored control, which is replaced afterwards
    always_comb begin
        init_evt   = evt.wr_ctrl && !wdata[CB_INIT];
        armed      = evt.wr_ctrl && wdata[CB_INIT] && wdata[CB_SELECT];
        strobe_evt = armed && wdata[CB_STROBE];
        emit_evt   = strobe_evt && !ctrl_q[CB_STROBE];
        set_pend   = armed && !wdata[CB_STROBE] && ctrl_q[CB_INTEN];
        ctrl_d     = evt.wr_ctrl ? wdata : ctrl_q;
        dout_d     = evt.wr_data ? wdata : dout_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            dout_q <= '0;
            sent_q <= 1'b0;
        end else begin
            ctrl_q <= ctrl_d;
            dout_q <= dout_d;
            sent_q <= emit_evt;
        end
    end

    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        sent_q |=> !sent_q);
    a_r6_no_resend: assert property (@(posedge clk) disable iff (!rst_n)
        (evt.wr_ctrl && ctrl_q[CB_STROBE]) |=> !sent_q);
    a_r8_ctrl_stored: assert property (@(posedge clk) disable iff (!rst_n)
        evt.wr_ctrl |=> ctrl_q == $past(wdata));
endmodule

// File: rtl/lpt_status_fsm.sv
module lpt_status_fsm
    import lpt_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_evt,
    input  logic              strobe_evt,
    input  logic              set_pend,
    input  logic              rd_stat,
    input  logic              ctrl_strobe,
    output logic [DATA_W-1:0] status,
    output logic              pend_q,
    output logic              pend_d
);
    hs_state_t st_q, st_d;
    logic online_q, error_q;

    always_comb begin
        st_d = st_q;
        if (init_evt) begin
            st_d = HS_BSY_ACK;
        end else if (strobe_evt) begin
            unique case (st_q)
                HS_BSY_ACK: st_d = HS_RDY_ACK;
                default:    st_d = st_q;
            endcase
        end else if (rd_stat && !ctrl_strobe) begin
            unique case (st_q)
                HS_RDY_ACK:   st_d = HS_RDY_NOACK;
                HS_RDY_NOACK: st_d = HS_BSY_ACK;
                default:      st_d = st_q;
            endcase
        end
        if (rd_stat)       pend_d = 1'b0;
        else if (set_pend) pend_d = 1'b1;
        else               pend_d = pend_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= HS_RDY_NOACK;
            online_q <= 1'b0;
            error_q  <= 1'b0;
            pend_q   <= 1'b0;
        end else begin
            st_q     <= st_d;
            online_q <= online_q | init_evt;
            error_q  <= error_q  | init_evt;
            pend_q   <= pend_d;
        end
    end

    always_comb begin
        status            = '0;
        status[SB_ERROR]  = error_q;
        status[SB_ONLINE] = online_q;
        unique case (st_q)
            HS_RDY_NOACK: begin status[SB_BUSY] = 1'b0; status[SB_ACK] = 1'b0; end
            HS_RDY_ACK:   begin status[SB_BUSY] = 1'b0; status[SB_ACK] = 1'b1; end
            HS_BSY_ACK:   begin status[SB_BUSY] = 1'b1; status[SB_ACK] = 1'b1; end
            default:      begin status[SB_BUSY] = 1'b0; status[SB_ACK] = 1'b0; end
        endcase
    end

    a_r4_init_forces: assert property (@(posedge clk) disable iff (!rst_n)
        init_evt |=> (status[SB_BUSY] && status[SB_ACK] && status[SB_ONLINE] && status[SB_ERROR]));
    a_r5_strobe_ready: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_evt |=> !status[SB_BUSY]);
    a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stat |=> !pend_q);
    a_r10_ack_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stat && !ctrl_strobe && st_q == HS_RDY_ACK) |=> st_q == HS_RDY_NOACK);
    a_r10_held: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stat && ctrl_strobe) |=> $stable(st_q));
endmodule

// File: rtl/lpt_port.sv
module lpt_port
    import lpt_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int WIN_BITS = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                acc_en,
    input  logic                acc_we,
    input  logic [WIN_BITS-1:0] acc_addr,
    input  logic [DATA_W-1:0]   acc_wdata,
    output logic [DATA_W-1:0]   acc_rdata,
    input  logic [DATA_W-1:0]   lp_din,
    output logic [DATA_W-1:0]   lp_dout,
    output logic                lp_sent,
    output logic                lp_irq
);
    bus_evt_t evt;
    logic [DATA_W-1:0] ctrl_q, ctrl_d, status;
    logic init_evt, strobe_evt, set_pend, pend_q, pend_d, irq_q;

    lpt_bus_decode #(.WIN_BITS(WIN_BITS)) u_dec (
        .acc_en(acc_en), .acc_we(acc_we), .acc_addr(acc_addr), .evt(evt));

    lpt_ctrl_unit #(.DATA_W(DATA_W)) u_ctl (
        .clk(clk), .rst_n(rst_n), .evt(evt), .wdata(acc_wdata),
        .ctrl_q(ctrl_q), .ctrl_d(ctrl_d), .dout_q(lp_dout),
        .init_evt(init_evt), .strobe_evt(strobe_evt), .set_pend(set_pend),
        .sent_q(lp_sent));

    lpt_status_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .init_evt(init_evt), .strobe_evt(strobe_evt),
        .set_pend(set_pend), .rd_stat(evt.rd_stat), .ctrl_strobe(ctrl_q[CB_STROBE]),
        .status(status), .pend_q(pend_q), .pend_d(pend_d));

    // R11: interrupt follows the post-access pending flag and enable
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= pend_d & ctrl_d[CB_INTEN];
    end
    assign lp_irq = irq_q;

    // R2, R3, R8, R9: read mux
    always_comb begin
        unique case (acc_addr)
            WIN_BITS'(OFS_DATA): acc_rdata = ctrl_q[CB_DIR] ? lp_din : lp_dout;
            WIN_BITS'(OFS_STAT): acc_rdata = status;
            WIN_BITS'(OFS_CTRL): acc_rdata = ctrl_q;
            default:             acc_rdata = '0;
        endcase
    end

    a_r11_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
        lp_irq == (pend_q && ctrl_q[CB_INTEN]));
    a_r12_stat_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_we && acc_addr == WIN_BITS'(OFS_STAT)) |=> $stable(status));
endmodule

// File: tb/lpt_port_test.sv
module lpt_port_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic b_en = 1'b0, b_we = 1'b0;
    logic [2:0] b_addr = '0;
    logic [7:0] b_wdata = '0, b_din = '0;
    logic [7:0] rdata, dout;
    logic sent, irq;

    int checks = 0, fails = 0, pulses = 0;

    // behavioural model state
    logic [7:0] m_dout = 0, m_ctrl = 0;
    bit m_busy = 0, m_ack = 0, m_onl = 0, m_err = 0, m_pend = 0, m_sent = 0, m_irq = 0;

    always #10 clk = ~clk;

    lpt_port uut (
        .clk(clk), .rst_n(rst_n), .acc_en(b_en), .acc_we(b_we), .acc_addr(b_addr),
        .acc_wdata(b_wdata), .acc_rdata(rdata), .lp_din(b_din), .lp_dout(dout),
        .lp_sent(sent), .lp_irq(irq));

    function automatic logic [7:0] m_status();
        return {m_busy, m_ack, 1'b0, m_onl, m_err, 3'b000};
    endfunction

    function automatic logic [7:0] m_read(input logic [2:0] a);
        case (a)
            3'd0: return m_ctrl[5] ? b_din : m_dout;
            3'd1: return m_status();
            3'd2: return m_ctrl;
            default: return 8'h00;
        endcase
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
        end
    endtask

    // reference model: one step per rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_dout = 0; m_ctrl = 0; m_busy = 0; m_ack = 0; m_onl = 0; m_err = 0;
            m_pend = 0; m_sent = 0; m_irq = 0;
        end else begin
            m_sent = 0;
            if (b_en && b_we && b_addr == 3'd0) m_dout = b_wdata;
            if (b_en && b_we && b_addr == 3'd2) begin
                if (!b_wdata[2]) begin
                    m_busy = 1; m_ack = 1; m_onl = 1; m_err = 1;
                end else if (b_wdata[3]) begin
                    if (b_wdata[0]) begin
                        m_busy = 0;
                        if (!m_ctrl[0]) m_sent = 1;
                    end else if (m_ctrl[4]) m_pend = 1;
                end
                m_ctrl = b_wdata;
            end
            if (b_en && !b_we && b_addr == 3'd1) begin
                m_pend = 0;
                if (!m_busy && !m_ctrl[0]) begin
                    if (m_ack) m_ack = 0;
                    else begin m_ack = 1; m_busy = 1; end
                end
            end
            m_irq = m_pend & m_ctrl[4];
        end
    end

    // per-clock comparison away from the edge
    always @(negedge clk) begin
        #2;
        if (rst_n) begin
            check("R3 lp_dout", dout, m_dout);
            check("R6 lp_sent", {7'd0, sent}, {7'd0, m_sent});
            check("R11 lp_irq", {7'd0, irq}, {7'd0, m_irq});
            if (sent) pulses++;
            if (b_en && !b_we) begin
                case (b_addr)
                    3'd0: check("R3 data read", rdata, m_read(b_addr));
                    3'd1: check("R9 status read", rdata, m_read(b_addr));
                    3'd2: check("R8 control read", rdata, m_read(b_addr));
                    default: check("R2 unused read", rdata, m_read(b_addr));
                endcase
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        b_en = 1; b_we = 1; b_addr = a; b_wdata = d;
        @(negedge clk);
        b_en = 0; b_we = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk);
        b_en = 1; b_we = 0; b_addr = a;
        #3 v = rdata;
        @(negedge clk);
        b_en = 0;
    endtask

    bit done = 0;
    initial begin
        #2000000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1;
        rd(3'd1, v); check("R1 reset status", v, 8'h00);
        rd(3'd2, v); check("R1 reset control", v, 8'h00);
        rd(3'd0, v); check("R1 reset data", v, 8'h00);
        check("R1 reset irq", {7'd0, irq}, 8'h00);
        // R3 output latch, R2 unused offsets
        wr(3'd0, 8'h5A); rd(3'd0, v); check("R3 out latch", v, 8'h5A);
        wr(3'd5, 8'hFF); rd(3'd5, v); check("R2 unused read", v, 8'h00);
        rd(3'd0, v); check("R2 unused write inert", v, 8'h5A);
        wr(3'd0, 8'h33);
        // direction bit selects input byte
        b_din = 8'hA7;
        wr(3'd2, 8'h2C); rd(3'd0, v); check("R3 dir input", v, 8'hA7);
        // R4 init
        wr(3'd2, 8'h08); rd(3'd1, v); check("R4 init status", v, 8'hD8);
        rd(3'd1, v); check("R10 busy holds", v, 8'hD8);
        // R5 strobe, R6 send
        wr(3'd2, 8'h0D); rd(3'd1, v); check("R5 busy cleared", v, 8'h58);
        check("R6 sent byte", dout, 8'h33);
        rd(3'd1, v); check("R10 strobe high holds", v, 8'h58);
        wr(3'd2, 8'h0D);
        check("R6 one pulse only", 8'(pulses), 8'd1);
        // R10 stepping
        wr(3'd2, 8'h0C);
        rd(3'd1, v); check("R10 ack set before", v, 8'h58);
        rd(3'd1, v); check("R10 ack dropped", v, 8'h18);
        rd(3'd1, v); check("R10 reload", v, 8'hD8);
        // R12 status write
        wr(3'd1, 8'h00); rd(3'd1, v); check("R12 status write inert", v, 8'hD8);
        // R7 pending needs previous enable
        wr(3'd2, 8'h1C); @(negedge clk); check("R7 no pend old disable", {7'd0, irq}, 8'h00);
        wr(3'd2, 8'h1C); @(negedge clk); check("R11 irq raised", {7'd0, irq}, 8'h01);
        rd(3'd1, v); @(negedge clk); check("R9 irq cleared by read", {7'd0, irq}, 8'h00);
        wr(3'd2, 8'h1C);
        wr(3'd2, 8'h0C); @(negedge clk); check("R11 irq masked", {7'd0, irq}, 8'h00);
        wr(3'd2, 8'h1D); @(negedge clk); check("R11 irq unmasked", {7'd0, irq}, 8'h01);
        rd(3'd2, v); check("R8 control readback", v, 8'h1D);
        wr(3'd2, 8'hC4); rd(3'd2, v); check("R8 full byte stored", v, 8'hC4);
        repeat (3) @(negedge clk);
        check("R6 pulse total", 8'(pulses), 8'd2);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule